// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This block forms the memory address for load and store operations and the target for relative branches. Each accepted input carries a mode code, a base register value, a signed immediate and the program counter of the instruction. Exactly one clock later the block presents the resulting memory address, the branch target, and, for the auto-updating mode, a write-back request with the new base register value. The register file and the memory system sit outside the block.

Four modes are supported. The first uses the base register directly as the address. The second adds the sign-extended immediate to the base before issuing. The third issues the untouched base and returns base plus immediate as a separate write-back value. The fourth adds a signed offset to the instruction's own program counter to form a branch target. In the direct and auto-updating modes the issued address comes from the base register through a multiplexer only; the adder output feeds the address only in the second mode. Immediates are sign-extended to the address width, and all sums wrap modulo 2^ADDR_W. A mode code outside the four defined ones produces all-zero results and raises an illegal-mode flag.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (direct): out_addr equals the base value, out_target and out_wb_data are zero, out_wb_en is low.
- R2: Mode code 1 (base plus offset): out_addr equals base plus the sign-extended immediate, modulo 2^ADDR_W; out_target and out_wb_data are zero.
- R3: Mode code 2 (post-update): out_addr equals the unmodified base, out_wb_data equals base plus the sign-extended immediate modulo 2^ADDR_W, out_target is zero.
- R4: Mode code 3 (relative branch): out_target equals the program counter plus the sign-extended immediate modulo 2^ADDR_W, with negative offsets moving backwards; out_addr and out_wb_data are zero.
- R5: out_wb_en is high only for a valid input with mode code 2, and low for every other code and for idle cycles.
- R6: Mode codes 4 to 7 raise out_illegal and give zero on out_addr, out_target and out_wb_data with out_wb_en low; codes 0 to 3 leave out_illegal low.
- R7: Every input with in_valid high gives its result with out_valid high exactly one clock later; a cycle with in_valid low gives out_valid low and every other output zero one clock later.
- R8: While rst is high at a clock edge, all outputs are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields carry an operation this cycle |
| in_mode | input | 3 | Addressing mode code (0 to 3 defined) |
| in_base | input | ADDR_W | Base register value |
| in_imm | input | IMM_W | Signed immediate or branch offset |
| in_pc | input | ADDR_W | Program counter of the instruction |
| out_valid | output | 1 | Result present |
| out_addr | output | ADDR_W | Memory address to issue |
| out_target | output | ADDR_W | Branch target |
| out_wb_en | output | 1 | Base register write-back request |
| out_wb_data | output | ADDR_W | Updated base register value |
| out_illegal | output | 1 | Undefined mode code seen |

## Verification
The bench builds the block with an 8-bit address and a 4-bit immediate. At that size every base value, every immediate from -8 to +7 and all eight mode codes, including the four undefined ones, are swept in full, so both upward and downward wrap-around of every sum is reached. Idle cycles between mode sweeps and a reset phase cover the zero-output cases.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_REG    = 3'd0,
    MODE_RIMM   = 3'd1,
    MODE_POST   = 3'd2,
    MODE_BRANCH = 3'd3
  } agu_mode_e;

  typedef struct packed {
    logic use_base;
    logic use_sum;
    logic wb;
    logic branch;
    logic illegal;
  } agu_sel_t;

endpackage

// File: rtl/agu_sext.sv
module agu_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int EXT_W = OUT_W - IN_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign dout = {{EXT_W{din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] mode,
  output agu_sel_t   sel
);
  always_comb begin
    sel = '0;
    if (valid) begin
      case (mode)
        MODE_REG:    sel.use_base = 1'b1;
        MODE_RIMM:   sel.use_sum  = 1'b1;
        MODE_POST: begin
          sel.use_base = 1'b1;
          sel.wb       = 1'b1;
        end
        MODE_BRANCH: sel.branch   = 1'b1;
        default:     sel.illegal  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [ADDR_W-1:0] in_pc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_wb_en,
  output logic [ADDR_W-1:0] out_wb_data,
  output logic              out_illegal
);
  agu_sel_t          sel;
  logic [ADDR_W-1:0] imm_x;
  logic [ADDR_W-1:0] base_sum;
  logic [ADDR_W-1:0] pc_sum;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] nxt_target;
  logic [ADDR_W-1:0] nxt_wb;

  agu_decode u_dec (
    .valid (in_valid),
    .mode  (in_mode),
    .sel   (sel)
  );

  agu_sext #(.IN_W(IMM_W), .OUT_W(ADDR_W)) u_sext (
    .din  (in_imm),
    .dout (imm_x)
  );

  // Base adder: feeds the address only in base-plus-offset mode,
  // and the write-back value in post-update mode.
  agu_adder #(.W(ADDR_W)) u_base_add (
    .a   (in_base),
    .b   (imm_x),
    .sum (base_sum)
  );

  agu_adder #(.W(ADDR_W)) u_pc_add (
    .a   (in_pc),
    .b   (imm_x),
    .sum (pc_sum)
  );

  always_comb begin
    nxt_addr = '0;
    if (sel.use_base) nxt_addr = in_base;
    else if (sel.use_sum) nxt_addr = base_sum;
  end

  assign nxt_target = sel.branch ? pc_sum : '0;
  assign nxt_wb     = sel.wb ? base_sum : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_target  <= '0;
      out_wb_en   <= 1'b0;
      out_wb_data <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_addr    <= nxt_addr;
      out_target  <= nxt_target;
      out_wb_en   <= sel.wb;
      out_wb_data <= nxt_wb;
      out_illegal <= sel.illegal;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_mode,
  input logic [ADDR_W-1:0] in_base,
  input logic [IMM_W-1:0]  in_imm,
  input logic [ADDR_W-1:0] in_pc,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] out_target,
  input logic              out_wb_en,
  input logic [ADDR_W-1:0] out_wb_data,
  input logic              out_illegal
);
  localparam int PAD_W = ADDR_W - IMM_W;
  logic [ADDR_W-1:0] chk_imm;
  assign chk_imm = {{PAD_W{in_imm[IMM_W-1]}}, in_imm};

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd0) |=> (out_addr == $past(in_base) && !out_wb_en)); // R1

  AST_OFFSET_ADDR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd1) |=> (out_addr == $past(in_base + chk_imm))); // R2

  AST_POST_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd2) |=> (out_addr == $past(in_base) && out_wb_data == $past(in_base + chk_imm))); // R3

  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd3) |=> (out_target == $past(in_pc + chk_imm) && out_addr == '0)); // R4

  AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_mode == 3'd2) |=> !out_wb_en); // R5

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode[2]) |=> (out_illegal && out_addr == '0 && out_target == '0 && !out_wb_en)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && out_addr == '0)); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
endmodule

bind agu_top agu_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_agu_top.sv
module sim_agu_top;
  localparam int AW = 8;
  localparam int IW = 4;
  localparam int AMOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_mode = '0;
  logic [AW-1:0] in_base = '0;
  logic [IW-1:0] in_imm = '0;
  logic [AW-1:0] in_pc = '0;
  logic          out_valid, out_wb_en, out_illegal;
  logic [AW-1:0] out_addr, out_target, out_wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit            pend = 1'b0;
  string         p_tag;
  logic          p_valid, p_wb, p_ill;
  logic [AW-1:0] p_addr, p_tgt, p_wbd;

  always #5 clk = ~clk;

  agu_top #(.ADDR_W(AW), .IMM_W(IW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_base(in_base), .in_imm(in_imm), .in_pc(in_pc),
    .out_valid(out_valid), .out_addr(out_addr), .out_target(out_target),
    .out_wb_en(out_wb_en), .out_wb_data(out_wb_data), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      chk("R7", "valid", int'(out_valid), int'(p_valid));
      chk(p_tag, "addr", int'(out_addr), int'(p_addr));
      chk(p_tag, "target", int'(out_target), int'(p_tgt));
      chk(p_tag, "wb_data", int'(out_wb_data), int'(p_wbd));
      chk("R5", "wb_en", int'(out_wb_en), int'(p_wb));
      chk("R6", "illegal", int'(out_illegal), int'(p_ill));
    end
  endtask

  task automatic step(input logic v, input int m, input int b, input int i, input int pc);
    int s;
    @(negedge clk);
    compare_pending();
    s = (i >= (1 << (IW - 1))) ? i - (1 << IW) : i;
    in_valid = v;
    in_mode  = 3'(m);
    in_base  = AW'(b);
    in_imm   = IW'(i);
    in_pc    = AW'(pc);
    p_valid = v;
    p_addr = '0; p_tgt = '0; p_wbd = '0; p_wb = 1'b0; p_ill = 1'b0;
    p_tag = "R7";
    if (v) begin
      case (m)
        0: begin p_tag = "R1"; p_addr = AW'(b); end
        1: begin p_tag = "R2"; p_addr = AW'(((b + s) % AMOD + AMOD) % AMOD); end
        2: begin
          p_tag = "R3"; p_addr = AW'(b); p_wb = 1'b1;
          p_wbd = AW'(((b + s) % AMOD + AMOD) % AMOD);
        end
        3: begin p_tag = "R4"; p_tgt = AW'(((pc + s) % AMOD + AMOD) % AMOD); end
        default: begin p_tag = "R6"; p_ill = 1'b1; end
      endcase
    end
    pend = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs while reset held
    chk("R8", "valid", int'(out_valid), 0);
    chk("R8", "addr", int'(out_addr), 0);
    chk("R8", "target", int'(out_target), 0);
    chk("R8", "wb", int'(out_wb_en) + int'(out_wb_data), 0);
    chk("R8", "illegal", int'(out_illegal), 0);
    rst = 1'b0;
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < AMOD; b++) begin
        for (int i = 0; i < (1 << IW); i++) begin
          step(1'b1, m, b, i, (b * 7 + i * 13 + m) % AMOD);
        end
      end
      // R7: idle cycle after each sweep, stale fields must not leak
      step(1'b0, 2, 8'hF0, 4'h7, 8'hAA);
    end
    step(1'b0, 0, 0, 0, 0);
    @(negedge clk);
    compare_pending();
    pend = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule